// File: doc/BRIEF.md
# Firing-Enable Input Conditioner

This block takes the two raw firing-enable pins of a squib-driver channel pair and turns each into a clean internal enable. Each pin first passes through a two-flop synchroniser. It then passes through a symmetric glitch filter, which accepts a new level only after that level has been seen for a whole filter window. Last comes a latch-and-hold stage. When the filtered input drops, this stage keeps the internal enable asserted for a programmed number of millisecond ticks. A rising filtered input always reloads the hold count. A filtered input that never drops never starts a countdown.

Each channel also gives a firing permit, which is the held enable gated by that channel's fire command. The block reports the synchronised raw pin level as status, so firmware sees the true pin state and not the extended one. Each channel's hold delay is an 8-bit millisecond count. A per-channel write strobe loads it. Reset returns the count to zero, and a zero count means there is no hold at all.

Top module: `fire_enable_conditioner`

## Requirements
- R1: `pin_status_o[c]` shows the pin level after three clock edges (two synchroniser flops plus the output register). It ignores the filter and the hold, so a short pulse also shows.
- R2: A high level on the synchronised pin raises the enable only if it lasts `FILT_CYC` consecutive samples. A shorter high pulse leaves `en_held_o[c]` low.
- R3: While the filtered input is high, `en_held_o[c]` is high. It rises `FILT_CYC`+3 edges after the pin rises.
- R4: A low pulse shorter than the filter window does not drop `en_held_o[c]`. It also does not start or consume the hold countdown.
- R5: With a programmed delay N (1..255), `en_held_o[c]` stays high after the filtered fall. It drops on the edge that samples the N-th `ms_tick_i` pulse counted after the fall.
- R6: A qualified rising edge during a running hold cancels that hold and reloads the count. The next fall then holds for the full N ticks.
- R7: With delay 0, the enable drops `FILT_CYC`+3 edges after the pin falls, with no hold. Delay 0 is the value after reset.
- R8: `dly_wr_i[c]` loads `dly_val_i[8c+7:8c]` into channel c only. The channels are independent.
- R9: `fire_permit_o[c]` is the registered AND of the held enable and `fire_cmd_i[c]`. Dropping the pin with no hold clears it. While the enable is up, it follows `fire_cmd_i[c]` one edge later.
- R10: A synchronous high `rst` clears all outputs, filters, holds and programmed delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin_i | input | NCH | Raw asynchronous enable pins |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| dly_wr_i | input | NCH | Per-channel delay load strobe |
| dly_val_i | input | NCH*DLY_W | Delay values, channel c in bits [DLY_W*c +: DLY_W] |
| fire_cmd_i | input | NCH | Per-channel fire command |
| en_held_o | output | NCH | Filtered and held enables |
| pin_status_o | output | NCH | Synchronised raw pin levels |
| fire_permit_o | output | NCH | Held enable gated by fire command |

## Verification
The bench builds the block with `FILT_CYC` = 8 and the default two channels with 8-bit delays. A pin edge therefore reaches the enable output within eleven cycles, and both sides of the filter window can be hit exactly. The bench drives millisecond ticks as single-cycle pulses it places itself. This lets it count a 3-tick and a 5-tick hold down to the edge where the enable drops. It also lets it show that a rise in mid-hold restores the full count.

// File: rtl/fen_cond_pkg.sv
package fen_cond_pkg;

  localparam int unsigned FILT_CYC_DEF = 1400;  // 14 us at 100 MHz
  localparam int unsigned DLY_W_DEF    = 8;
  localparam int unsigned SYNC_DEF     = 2;

  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_RUN  = 1'b1
  } hold_state_e;

endpackage

// File: rtl/fen_sync.sv
module fen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/fen_glitch_filter.sv
module fen_glitch_filter #(
  parameter int unsigned FILT_CYC = 1400
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic filt_o
);

  localparam int unsigned       CNT_W    = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(FILT_CYC - 1);
  localparam logic [CNT_W:0]    RUN_MAX  = (CNT_W+1)'(FILT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             filt_q;

  // A new level is adopted only after FILT_CYC consecutive disagreeing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (din_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_q <= din_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // Independent run-length tracker used only by the checks below.
  logic           chk_prev;
  logic [CNT_W:0] chk_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_prev <= 1'b0;
      chk_run  <= '0;
    end else begin
      chk_prev <= din_i;
      if (din_i != chk_prev)    chk_run <= (CNT_W+1)'(1);
      else if (chk_run != RUN_MAX) chk_run <= chk_run + 1'b1;
    end
  end

  assert_filter_window_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_q) |-> (chk_run >= RUN_MAX));

  assert_low_pulse_rejected_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(filt_q) |-> (chk_run >= RUN_MAX));

endmodule

// File: rtl/fen_hold_timer.sv
module fen_hold_timer
  import fen_cond_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             filt_i,
  input  logic             tick_i,
  input  logic             dly_wr_i,
  input  logic [DLY_W-1:0] dly_val_i,
  input  logic             fire_cmd_i,
  output logic             held_o,
  output logic             permit_o
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] dly_q, cnt_q, cnt_n;
  logic             filt_d;
  hold_state_e      st_q, st_n;
  logic             rise, fall, en_n;

  always_comb begin
    rise  = filt_i & ~filt_d;
    fall  = ~filt_i & filt_d;
    st_n  = st_q;
    cnt_n = cnt_q;
    if (rise) begin
      st_n  = HOLD_IDLE;
      cnt_n = dly_q;
    end else if (fall) begin
      st_n  = (cnt_q != '0) ? HOLD_RUN : HOLD_IDLE;
    end else if ((st_q == HOLD_RUN) && tick_i) begin
      cnt_n = cnt_q - ONE;
      if (cnt_q == ONE) st_n = HOLD_IDLE;
    end
    en_n = filt_i | (st_n == HOLD_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q    <= '0;
      cnt_q    <= '0;
      filt_d   <= 1'b0;
      st_q     <= HOLD_IDLE;
      held_o   <= 1'b0;
      permit_o <= 1'b0;
    end else begin
      if (dly_wr_i) dly_q <= dly_val_i;
      filt_d   <= filt_i;
      cnt_q    <= cnt_n;
      st_q     <= st_n;
      held_o   <= en_n;
      permit_o <= en_n & fire_cmd_i;
    end
  end

  assert_follow_high_R3: assert property (@(posedge clk) disable iff (rst)
    filt_i |=> held_o);

  assert_count_live_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == HOLD_RUN) |-> (cnt_q != '0));

  assert_reload_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (filt_i && !filt_d) |=> (cnt_q == $past(dly_q)));

  assert_zero_no_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!filt_i && filt_d && (cnt_q == '0)) |=> !held_o);

  assert_permit_gated_R9: assert property (@(posedge clk) disable iff (rst)
    permit_o |-> held_o);

endmodule

// File: rtl/fen_channel.sv
module fen_channel #(
  parameter int unsigned FILT_CYC    = 1400,
  parameter int unsigned DLY_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             tick_i,
  input  logic             dly_wr_i,
  input  logic [DLY_W-1:0] dly_val_i,
  input  logic             fire_cmd_i,
  output logic             held_o,
  output logic             status_o,
  output logic             permit_o
);

  logic pin_s, filt;

  fen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  fen_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk    (clk),
    .rst    (rst),
    .din_i  (pin_s),
    .filt_o (filt)
  );

  fen_hold_timer #(.DLY_W(DLY_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .filt_i     (filt),
    .tick_i     (tick_i),
    .dly_wr_i   (dly_wr_i),
    .dly_val_i  (dly_val_i),
    .fire_cmd_i (fire_cmd_i),
    .held_o     (held_o),
    .permit_o   (permit_o)
  );

  // Status reports the synchronised pin, bypassing filter and hold.
  always_ff @(posedge clk) begin
    if (rst) status_o <= 1'b0;
    else     status_o <= pin_s;
  end

endmodule

// File: rtl/fire_enable_conditioner.sv
module fire_enable_conditioner
  import fen_cond_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned DLY_W       = DLY_W_DEF,
  parameter int unsigned FILT_CYC    = FILT_CYC_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       en_pin_i,
  input  logic                 ms_tick_i,
  input  logic [NCH-1:0]       dly_wr_i,
  input  logic [NCH*DLY_W-1:0] dly_val_i,
  input  logic [NCH-1:0]       fire_cmd_i,
  output logic [NCH-1:0]       en_held_o,
  output logic [NCH-1:0]       pin_status_o,
  output logic [NCH-1:0]       fire_permit_o
);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      fen_channel #(
        .FILT_CYC    (FILT_CYC),
        .DLY_W       (DLY_W),
        .SYNC_STAGES (SYNC_STAGES)
      ) u_ch (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (en_pin_i[c]),
        .tick_i     (ms_tick_i),
        .dly_wr_i   (dly_wr_i[c]),
        .dly_val_i  (dly_val_i[DLY_W*c +: DLY_W]),
        .fire_cmd_i (fire_cmd_i[c]),
        .held_o     (en_held_o[c]),
        .status_o   (pin_status_o[c]),
        .permit_o   (fire_permit_o[c])
      );
    end
  endgenerate

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> ((en_held_o == '0) && (fire_permit_o == '0) && (pin_status_o == '0)));

endmodule

// File: tb/tb_fire_enable_conditioner.sv
module tb_fire_enable_conditioner;

  localparam int unsigned NCH = 2;
  localparam int unsigned DW  = 8;
  localparam int unsigned FC  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]    en_pin = '0;
  logic              tick = 1'b0;
  logic [NCH-1:0]    dly_wr = '0;
  logic [NCH*DW-1:0] dly_val = '0;
  logic [NCH-1:0]    fire = '0;
  logic [NCH-1:0]    held, stat, perm;

  always #5 clk = ~clk;

  fire_enable_conditioner #(.NCH(NCH), .DLY_W(DW), .FILT_CYC(FC)) dut (
    .clk           (clk),
    .rst           (rst),
    .en_pin_i      (en_pin),
    .ms_tick_i     (tick),
    .dly_wr_i      (dly_wr),
    .dly_val_i     (dly_val),
    .fire_cmd_i    (fire),
    .en_held_o     (held),
    .pin_status_o  (stat),
    .fire_permit_o (perm)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Scoreboard queues: field 0 = held, 1 = status, 2 = permit
  string q_tag[$];
  int    q_ch[$];
  int    q_fld[$];
  logic  q_exp[$];

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int ch, input int fld, input logic v);
    q_tag.push_back(tag);
    q_ch.push_back(ch);
    q_fld.push_back(fld);
    q_exp.push_back(v);
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(1);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: compares queued expectations in the quiet half of the cycle.
  always @(negedge clk) begin
    while (q_tag.size() != 0) begin
      string t;
      int    c, f;
      logic  e, a;
      t = q_tag.pop_front();
      c = q_ch.pop_front();
      f = q_fld.pop_front();
      e = q_exp.pop_front();
      a = (f == 0) ? held[c] : (f == 1) ? stat[c] : perm[c];
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s ch%0d field%0d actual=%0b expected=%0b", t, c, f, a, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    for (int c = 0; c < 2; c++) begin
      chk("R10 reset state", c, 0, 1'b0);
      chk("R10 reset state", c, 1, 1'b0);
      chk("R10 reset state", c, 2, 1'b0);
    end

    // Default delay 0: latency and no hold
    fire = 2'b01;
    en_pin[0] = 1'b1;
    step(2); chk("R1 status not yet", 0, 1, 1'b0);
    step(1); chk("R1 status raw", 0, 1, 1'b1);
    step(7); chk("R3 before window", 0, 0, 1'b0);
    step(1); chk("R3 held high", 0, 0, 1'b1);
    chk("R9 permit with fire", 0, 2, 1'b1);
    chk("R8 other channel idle", 1, 0, 1'b0);
    en_pin[0] = 1'b0;
    step(10); chk("R7 still high in window", 0, 0, 1'b1);
    step(1);  chk("R7 no hold at delay 0", 0, 0, 1'b0);
    chk("R9 permit drops", 0, 2, 1'b0);

    // Short high pulse on channel 1
    en_pin[1] = 1'b1;
    step(3); chk("R1 status shows short pulse", 1, 1, 1'b1);
    step(2); en_pin[1] = 1'b0;
    for (int i = 0; i < 16; i++) begin
      step(1); chk("R2 short high rejected", 1, 0, 1'b0);
    end

    // Program delays: ch0 = 3, ch1 = 5 (ch0 ignores 99 on second write)
    dly_val = {8'd0, 8'd3};  dly_wr = 2'b01; step(1);
    dly_val = {8'd5, 8'd99}; dly_wr = 2'b10; step(1);
    dly_wr = 2'b00;

    // Hold of 3 ticks on ch0
    en_pin[0] = 1'b1; step(11); chk("R5 enabled", 0, 0, 1'b1);
    en_pin[0] = 1'b0; step(11); chk("R5 hold started", 0, 0, 1'b1);
    pulse_tick(2);            chk("R5 held after 2 ticks", 0, 0, 1'b1);
    chk("R8 ch0 kept value 3", 0, 2, 1'b1);
    tick = 1'b1; step(1); tick = 1'b0;
    chk("R5 drops on 3rd tick", 0, 0, 1'b0);
    chk("R9 permit ends with hold", 0, 2, 1'b0);

    // Short low pulse must not start or consume the hold
    en_pin[0] = 1'b1; step(11); chk("R4 enabled", 0, 0, 1'b1);
    en_pin[0] = 1'b0; step(4); en_pin[0] = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(1); chk("R4 short low ignored", 0, 0, 1'b1);
    end
    en_pin[0] = 1'b0; step(11); chk("R4 real fall holds", 0, 0, 1'b1);
    pulse_tick(2);            chk("R4 full count kept", 0, 0, 1'b1);
    tick = 1'b1; step(1); tick = 1'b0;
    chk("R4 hold ends on 3rd tick", 0, 0, 1'b0);

    // Reload on rise during a running hold, ch1 delay 5
    en_pin[1] = 1'b1; step(11); chk("R8 ch1 enabled", 1, 0, 1'b1);
    chk("R9 no permit without fire", 1, 2, 1'b0);
    en_pin[1] = 1'b0; step(11); chk("R6 hold started", 1, 0, 1'b1);
    pulse_tick(3);
    en_pin[1] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step(1); chk("R6 held across rise", 1, 0, 1'b1);
    end
    en_pin[1] = 1'b0; step(11);
    pulse_tick(4);            chk("R6 reloaded count", 1, 0, 1'b1);
    fire[1] = 1'b1; step(1);  chk("R9 permit follows fire", 1, 2, 1'b1);
    tick = 1'b1; step(1); tick = 1'b0;
    chk("R6 drops on 5th tick", 1, 0, 1'b0);
    chk("R9 permit off", 1, 2, 1'b0);

    // Permit re-enable by fire command
    fire[0] = 1'b0;
    en_pin[0] = 1'b1; step(11); chk("R9 held no fire", 0, 2, 1'b0);
    fire[0] = 1'b1; step(1);   chk("R9 fire re-enables", 0, 2, 1'b1);
    fire[0] = 1'b0; step(1);   chk("R9 fire removed", 0, 2, 1'b0);

    // Reset clears outputs and programmed delays
    en_pin = 2'b00; rst = 1'b1; step(2);
    for (int c = 0; c < 2; c++) begin
      chk("R10 cleared", c, 0, 1'b0);
      chk("R10 cleared", c, 1, 1'b0);
      chk("R10 cleared", c, 2, 1'b0);
    end
    rst = 1'b0; step(1);
    en_pin = 2'b11; step(11);
    chk("R7 up after reset", 0, 0, 1'b1);
    chk("R7 up after reset", 1, 0, 1'b1);
    en_pin = 2'b00; step(11);
    chk("R7 delay back to 0", 0, 0, 1'b0);
    chk("R7 delay back to 0", 1, 0, 1'b0);

    step(2);
    done = 1;
    report();
  end

endmodule